// File: doc/BRIEF.md
# Dual-Region Write-Unlock Key Guard

This guard sits in front of the programming sequencer of an on-chip nonvolatile memory. It keeps two regions write-locked, program memory and data memory, until software proves intent. Software proves intent by writing a fixed pair of 8-bit keys, in order, to the key register of that region. The guard watches a simple register-write bus. Each region has its own key register and its own key pair. A correct pair sets the unlock bit of that region.

The two regions handle a wrong key differently. A wrong program key disables the program-region sequence until the next reset. A wrong data key only restarts the data-region sequence, so software can retry at once.

A write to the status register relocks a region when the matching bit is written as 0.

The guard derives three write enables from the unlock bits:
- Program writes are allowed only outside the protected pages at the bottom of the program array. These are the private-code pages followed by the boot pages.
- Data writes are allowed whenever the data region is unlocked.
- Option-area writes are allowed when the data region is unlocked and the option-access control input is also 1.

Top module: `kg_top`

## Requirements
- R1: After reset, `prog_unlocked_o`, `data_unlocked_o` and all three write enables are 0.
- R2: Writing `PROG_KEY_A` and then `PROG_KEY_B` to the program key address (default 2) sets `prog_unlocked_o`. The bit is visible in the cycle after the clock edge that captures the second write.
- R3: Writing `DATA_KEY_A` and then `DATA_KEY_B` to the data key address (default 3) sets `data_unlocked_o`. A key sequence on one region's address never unlocks the other region.
- R4: A key whose value is not the key expected at the current step is a wrong key. This includes the second key written first, or a key of the other region.
- R5: After any wrong key on the program key address, no later key sequence sets `prog_unlocked_o` until `rst_ni` is asserted.
- R6: After a wrong key on the data key address, the data sequence returns to its first step. A fresh correct pair then sets `data_unlocked_o` without a reset.
- R7: A write to the status address (default 7) relocks a region when its bit is 0. Bit 0 belongs to the program region and bit 1 to the data region. Writing a 1 never sets an unlock bit.
- R8: While a region is unlocked, writes to its key address have no effect. They neither lock the region nor disable the later sequence after a relock.
- R9: Pages `[0, priv_pages_i)` hold private code and pages `[priv_pages_i, priv_pages_i+boot_pages_i)` hold boot code. `prog_wr_en_o` is 1 only when the program region is unlocked and `tgt_page_i >= priv_pages_i + boot_pages_i`.
- R10: `data_wr_en_o` equals `data_unlocked_o`. `opt_wr_en_o` is 1 only when `data_unlocked_o` and `opt_ctrl_i` are both 1.
- R11: A partial key sequence on one region is kept across bus writes to the other region's key address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | KEY_W | Register write data |
| opt_ctrl_i | input | 1 | Option-area access control bit |
| tgt_page_i | input | PAGE_W | Program page targeted by the sequencer |
| priv_pages_i | input | PAGE_W | Number of private-code pages at page 0 |
| boot_pages_i | input | PAGE_W | Number of boot pages above the private pages |
| prog_unlocked_o | output | 1 | Program region unlock status |
| data_unlocked_o | output | 1 | Data region unlock status |
| prog_wr_en_o | output | 1 | Program write permitted for `tgt_page_i` |
| data_wr_en_o | output | 1 | Data write permitted |
| opt_wr_en_o | output | 1 | Option-area write permitted |

## Verification
Every fault in the key sequencer shows up on an unlock output one cycle after the write that exposes it:
- A sequencer stuck on its second step, a missing lockout, or a lockout that clears wrongly makes an unlock bit rise where it must stay low, or stay low where it must rise.
- A region that relocks without a status write shows up in the same way.

Stimulus covers these patterns:
- Ordered and reversed key pairs.
- Keys of the wrong region.
- Retries after failure.
- Ignored writes while a region is open.
- Interleaved sequences on both regions.

Page-window errors show up at once on `prog_wr_en_o` when `tgt_page_i` sits on either side of the protected boundary.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic [1:0] {
    SEQ_WAIT_A = 2'd0,
    SEQ_WAIT_B = 2'd1,
    SEQ_OPEN   = 2'd2,
    SEQ_DEAD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/kg_key_seq.sv
module kg_key_seq
  import kg_pkg::*;
#(
  parameter int unsigned      KEY_W       = 8,
  parameter logic [KEY_W-1:0] KEY_A       = 8'h3C,
  parameter logic [KEY_W-1:0] KEY_B       = 8'hC3,
  parameter bit               STICKY_FAIL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             relock_i,
  output logic             open_o
);
  localparam seq_state_e FAIL_ST = STICKY_FAIL ? SEQ_DEAD : SEQ_WAIT_A;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_WAIT_A: if (key_wr_i) state_d = (key_i == KEY_A) ? SEQ_WAIT_B : FAIL_ST;
      SEQ_WAIT_B: if (key_wr_i) state_d = (key_i == KEY_B) ? SEQ_OPEN   : FAIL_ST;
      SEQ_OPEN:   if (relock_i) state_d = SEQ_WAIT_A;
      SEQ_DEAD:   state_d = SEQ_DEAD;
      default:    state_d = SEQ_WAIT_A;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_WAIT_A;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == SEQ_OPEN);

  // R2
  open_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(state_q == SEQ_WAIT_B && key_wr_i && key_i == KEY_B));

  // R7
  open_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(open_o) |-> $past(relock_i));

  // R8
  open_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !relock_i) |=> open_o);

  generate
    if (STICKY_FAIL) begin : g_sticky
      // R5
      dead_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_DEAD) |=> (state_q == SEQ_DEAD && !open_o));
    end else begin : g_retry
      // R6
      retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_WAIT_B && key_wr_i && key_i != KEY_B) |=> (state_q == SEQ_WAIT_A));
    end
  endgenerate
endmodule

// File: rtl/kg_region_gate.sv
module kg_region_gate #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_open_i,
  input  logic              data_open_i,
  input  logic              opt_ctrl_i,
  input  logic [PAGE_W-1:0] tgt_page_i,
  input  logic [PAGE_W-1:0] priv_pages_i,
  input  logic [PAGE_W-1:0] boot_pages_i,
  output logic              prog_wr_en_o,
  output logic              data_wr_en_o,
  output logic              opt_wr_en_o
);
  localparam int unsigned SUM_W = PAGE_W + 1;

  logic [SUM_W-1:0] prot_end;
  logic             in_free_area;

  // private pages first, boot pages above them
  assign prot_end     = SUM_W'(priv_pages_i) + SUM_W'(boot_pages_i);
  assign in_free_area = SUM_W'(tgt_page_i) >= prot_end;

  assign prog_wr_en_o = prog_open_i && in_free_area;
  assign data_wr_en_o = data_open_i;
  assign opt_wr_en_o  = data_open_i && opt_ctrl_i;

  // R9
  prog_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_wr_en_o |-> (prog_open_i && tgt_page_i >= priv_pages_i));

  // R10
  opt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_wr_en_o |-> (data_wr_en_o && opt_ctrl_i));
endmodule

// File: rtl/kg_top.sv
module kg_top #(
  parameter int unsigned      ADDR_W        = 4,
  parameter int unsigned      KEY_W         = 8,
  parameter int unsigned      PAGE_W        = 8,
  parameter logic [ADDR_W-1:0] PROG_KEY_ADDR = 4'd2,
  parameter logic [ADDR_W-1:0] DATA_KEY_ADDR = 4'd3,
  parameter logic [ADDR_W-1:0] STAT_ADDR     = 4'd7,
  parameter logic [KEY_W-1:0] PROG_KEY_A    = 8'h3C,
  parameter logic [KEY_W-1:0] PROG_KEY_B    = 8'hC3,
  parameter logic [KEY_W-1:0] DATA_KEY_A    = 8'h5A,
  parameter logic [KEY_W-1:0] DATA_KEY_B    = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0]  wr_data_i,
  input  logic              opt_ctrl_i,
  input  logic [PAGE_W-1:0] tgt_page_i,
  input  logic [PAGE_W-1:0] priv_pages_i,
  input  logic [PAGE_W-1:0] boot_pages_i,
  output logic              prog_unlocked_o,
  output logic              data_unlocked_o,
  output logic              prog_wr_en_o,
  output logic              data_wr_en_o,
  output logic              opt_wr_en_o
);
  localparam int unsigned PROG_STAT_BIT = 0;
  localparam int unsigned DATA_STAT_BIT = 1;

  logic prog_key_wr, data_key_wr, stat_wr;
  logic prog_relock, data_relock;

  assign prog_key_wr = wr_en_i && (wr_addr_i == PROG_KEY_ADDR);
  assign data_key_wr = wr_en_i && (wr_addr_i == DATA_KEY_ADDR);
  assign stat_wr     = wr_en_i && (wr_addr_i == STAT_ADDR);
  assign prog_relock = stat_wr && !wr_data_i[PROG_STAT_BIT];
  assign data_relock = stat_wr && !wr_data_i[DATA_STAT_BIT];

  kg_key_seq #(
    .KEY_W(KEY_W), .KEY_A(PROG_KEY_A), .KEY_B(PROG_KEY_B), .STICKY_FAIL(1'b1)
  ) u_prog_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(prog_key_wr), .key_i(wr_data_i),
    .relock_i(prog_relock), .open_o(prog_unlocked_o)
  );

  kg_key_seq #(
    .KEY_W(KEY_W), .KEY_A(DATA_KEY_A), .KEY_B(DATA_KEY_B), .STICKY_FAIL(1'b0)
  ) u_data_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(data_key_wr), .key_i(wr_data_i),
    .relock_i(data_relock), .open_o(data_unlocked_o)
  );

  kg_region_gate #(.PAGE_W(PAGE_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prog_open_i(prog_unlocked_o), .data_open_i(data_unlocked_o),
    .opt_ctrl_i(opt_ctrl_i), .tgt_page_i(tgt_page_i),
    .priv_pages_i(priv_pages_i), .boot_pages_i(boot_pages_i),
    .prog_wr_en_o(prog_wr_en_o), .data_wr_en_o(data_wr_en_o), .opt_wr_en_o(opt_wr_en_o)
  );

  // R3
  region_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_unlocked_o) |-> $past(data_key_wr));

  // R1
  reset_lock_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!prog_unlocked_o && !data_unlocked_o && !opt_wr_en_o));
endmodule

// File: tb/tb_kg_top.sv
`timescale 1ns/1ps
module tb_kg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       opt_ctrl = 1'b0;
  logic [7:0] tgt_page = '0, priv_pages = '0, boot_pages = '0;
  logic       prog_ul, data_ul, prog_we, data_we, opt_we;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  kg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .opt_ctrl_i(opt_ctrl), .tgt_page_i(tgt_page), .priv_pages_i(priv_pages),
    .boot_pages_i(boot_pages), .prog_unlocked_o(prog_ul), .data_unlocked_o(data_ul),
    .prog_wr_en_o(prog_we), .data_wr_en_o(data_we), .opt_wr_en_o(opt_we)
  );

  localparam logic [3:0] PK = 4'd2, DK = 4'd3, ST = 4'd7;

  // {req[3:0], addr[3:0], data[7:0], exp_prog, exp_data}
  localparam logic [17:0] VEC [21] = '{
    {4'd2,  PK, 8'h3C, 1'b0, 1'b0},  // R2 first program key
    {4'd2,  PK, 8'hC3, 1'b1, 1'b0},  // R2 program opens
    {4'd4,  DK, 8'hA5, 1'b1, 1'b0},  // R4 second data key first
    {4'd6,  DK, 8'h5A, 1'b1, 1'b0},  // R6 retry at once
    {4'd6,  DK, 8'hA5, 1'b1, 1'b1},  // R6 data opens after retry
    {4'd8,  PK, 8'h00, 1'b1, 1'b1},  // R8 junk while open ignored
    {4'd7,  ST, 8'h02, 1'b0, 1'b1},  // R7 relock program only
    {4'd8,  PK, 8'h3C, 1'b0, 1'b1},  // R8 no lockout left by junk
    {4'd8,  PK, 8'hC3, 1'b1, 1'b1},
    {4'd7,  ST, 8'h01, 1'b1, 1'b0},  // R7 relock data only
    {4'd7,  ST, 8'h03, 1'b1, 1'b0},  // R7 writing ones sets nothing
    {4'd4,  DK, 8'h3C, 1'b1, 1'b0},  // R4 program key on data address
    {4'd7,  ST, 8'h00, 1'b0, 1'b0},
    {4'd11, PK, 8'h3C, 1'b0, 1'b0},  // R11 interleaved halves
    {4'd11, DK, 8'h5A, 1'b0, 1'b0},
    {4'd11, PK, 8'hC3, 1'b1, 1'b0},
    {4'd3,  DK, 8'hA5, 1'b1, 1'b1},  // R3 data pair, independent
    {4'd7,  ST, 8'h00, 1'b0, 1'b0},
    {4'd5,  PK, 8'h00, 1'b0, 1'b0},  // R5 wrong program key
    {4'd5,  PK, 8'h3C, 1'b0, 1'b0},
    {4'd5,  PK, 8'hC3, 1'b0, 1'b0}   // R5 stays locked
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 prog", prog_ul, 1'b0);
    chk("R1 data", data_ul, 1'b0);
    chk("R1 opt", opt_we, 1'b0);

    for (int i = 0; i < 21; i++) begin
      bus_wr(VEC[i][13:10], VEC[i][9:2]);
      checks++;
      if (prog_ul !== VEC[i][1] || data_ul !== VEC[i][0]) begin
        errors++;
        $display("FAIL R%0d step %0d: actual=%0b%0b expected=%0b%0b",
                 VEC[i][17:14], i, prog_ul, data_ul, VEC[i][1], VEC[i][0]);
      end
    end

    // R5 lockout cleared only by reset
    do_reset();
    chk("R1 after reset", prog_ul, 1'b0);
    bus_wr(PK, 8'h3C); bus_wr(PK, 8'hC3);
    chk("R5 reset reopens", prog_ul, 1'b1);

    // R4 reversed program pair disables region
    do_reset();
    bus_wr(PK, 8'hC3); bus_wr(PK, 8'h3C); bus_wr(PK, 8'hC3);
    chk("R4 reversed program pair", prog_ul, 1'b0);

    // R3 data keys on program address do not open either region
    do_reset();
    bus_wr(PK, 8'h5A); bus_wr(PK, 8'hA5);
    chk("R3 data keys on program addr", prog_ul, 1'b0);
    chk("R3 data stays locked", data_ul, 1'b0);

    // R9 protected window: private 0..1, boot 2..4
    do_reset();
    priv_pages = 8'd2; boot_pages = 8'd3; tgt_page = 8'd5;
    #1 chk("R9 locked free page", prog_we, 1'b0);
    bus_wr(PK, 8'h3C); bus_wr(PK, 8'hC3);
    chk("R9 first free page", prog_we, 1'b1);
    tgt_page = 8'd4; #1 chk("R9 last boot page", prog_we, 1'b0);
    tgt_page = 8'd0; #1 chk("R9 private page", prog_we, 1'b0);
    tgt_page = 8'd200; #1 chk("R9 high page", prog_we, 1'b1);

    // R10 data and option enables
    chk("R10 data locked", data_we, 1'b0);
    bus_wr(DK, 8'h5A); bus_wr(DK, 8'hA5);
    chk("R10 data enable", data_we, 1'b1);
    opt_ctrl = 1'b0; #1 chk("R10 opt needs ctrl", opt_we, 1'b0);
    opt_ctrl = 1'b1; #1 chk("R10 opt enable", opt_we, 1'b1);
    bus_wr(ST, 8'h01);
    chk("R10 opt follows data lock", opt_we, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule